// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM from a three-wire serial link (bit clock, word clock, data) and turns it into parallel left/right samples. The three link wires are brought into the system-clock domain through a synchronizer. Rising edges of the bit clock are found by edge detection, so the system clock has to run several times faster than the bit clock. Every word is shifted in MSB first and is presented as a 24-bit value aligned to the top bit.

A static format input chooses the framing. Low selects right-justified framing: the 16-bit word ends on the last bit-clock edge before the word clock changes, and the word clock is high for the left channel. High selects I2S framing: the word starts one bit clock after the word-clock change, the word clock is low for the left channel, and words of up to 24 bits are accepted.

The receiver measures the length of every word-clock half. Halves of exactly 16 bit clocks are accepted as packed 16-bit data. Halves that are too short set a sticky error flag and are discarded. A left/right pair is released with a one-cycle strobe once the right half of a frame completes.

Top module: `serial_audio_rx`

## Requirements
- R1: Data and word clock are taken on rising bit-clock edges only, and every word is assembled MSB first.
- R2: With `fmt_i2s` high, bit position 0 (MSB) of a word is the data taken on the second rising edge after a word-clock change. A half with word clock low is the left channel and a half with word clock high is the right channel.
- R3: In I2S framing, the first 24 positions of a half fill output bits 23 down to 0. A word shorter than 24 bits gives zeros in the low-order bits, and positions after the 24th are dropped.
- R4: With `fmt_i2s` low, the sample is the 16 bits taken on the 16 rising edges that end with the edge just before the word-clock change. These bits go to output bits 23..8, and bits 7..0 are zero. Word clock high is the left channel.
- R5: In right-justified framing, data taken earlier in a half than its last 16 edges has no effect on the output.
- R6: `pack16_o` is high together with a pair exactly when both of its halves lasted exactly 16 bit clocks.
- R7: A half shorter than the minimum sets `frame_err_o`, which stays high until reset, and no pair is released for that frame. The minimum is 24 bit clocks (or exactly 16) in I2S framing and 16 in right-justified framing.
- R8: `pair_valid_o` is a one-cycle pulse after a valid right half that follows a valid left half. `left_o` and `right_o` are updated in that same cycle.
- R9: The half in progress when reset is released is never evaluated, so it can produce neither a pair nor an error.
- R10: During and directly after reset, all outputs are zero.
- R11: The two halves may differ in length. Each is judged only against its own minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s | input | 1 | Framing select, static: 1 = I2S, 0 = 16-bit right-justified |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Serial word clock |
| sdata_i | input | 1 | Serial data |
| left_o | output | 24 | Left sample, aligned to the top bit |
| right_o | output | 24 | Right sample, aligned to the top bit |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is present |
| pack16_o | output | 1 | Pair came from two exactly-16-clock halves |
| frame_err_o | output | 1 | Sticky short-half error flag |

## Verification
On one bit-clock edge, a word-clock change does two things: it ends the old half, and in I2S framing it carries that half's final bit. The same edge also decides whether a pair is released or an error is raised. The bench provokes this by sending a 24-clock half whose LSB is 1, which must land in the old word while the new half's counting starts. It also sends a short right half right after a good left half, so that error setting and pair suppression fall on the same close. A behavioural model fed from the same bit stream predicts every pair and the error state. Pairs are compared on every clock, and the error flag is checked after each half.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {FMT_RJ = 1'b0, FMT_I2S = 1'b1} fmt_e;

  // Left channel is word clock low in I2S framing, high in right-justified framing.
  function automatic logic half_is_left(input logic fmt, input logic ws_level);
    return (fmt == FMT_I2S) ? ~ws_level : ws_level;
  endfunction
endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic tick_o,
  output logic ws_o,
  output logic sd_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][2:0] pipe;
  logic                   sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe  <= '0;
      sck_d <= 1'b0;
    end else begin
      pipe[0] <= {sck_i, ws_i, sd_i};
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      sck_d <= pipe[LAST][2];
    end
  end

  assign tick_o = pipe[LAST][2] & ~sck_d;
  assign ws_o   = pipe[LAST][1];
  assign sd_o   = pipe[LAST][0];

  // R1
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst) tick_o |=> !tick_o);
endmodule

// File: rtl/sar_deser.sv
module sar_deser import sar_pkg::*; #(
  parameter int SAMPLE_W = 24,
  parameter int RJ_W     = 16,
  parameter int PACK_W   = 16,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fmt_i2s,
  input  logic                tick,
  input  logic                ws,
  input  logic                sd,
  output logic                close_stb,
  output logic                close_left,
  output logic                close_ok,
  output logic                close_pack,
  output logic [SAMPLE_W-1:0] close_data
);
  localparam int               PAD_W    = SAMPLE_W - RJ_W;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] I2S_MIN  = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] RJ_MIN   = CNT_W'(RJ_W);
  localparam logic [CNT_W-1:0] PACK_LEN = CNT_W'(PACK_W);

  logic                primed, synced, ws_prev;
  logic [CNT_W-1:0]    cnt, wpos;
  logic [SAMPLE_W-1:0] acc, acc_w;
  logic [RJ_W-1:0]     rjsr;
  logic                level_change, len_ok;

  assign level_change = tick && primed && (ws != ws_prev);

  always_comb begin
    acc_w = acc;
    for (int i = 0; i < SAMPLE_W; i++)
      if (wpos == CNT_W'(SAMPLE_W - 1 - i)) acc_w[i] = sd;
  end

  assign len_ok = (fmt_i2s == FMT_I2S) ? ((cnt >= I2S_MIN) || (cnt == PACK_LEN))
                                       : (cnt >= RJ_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed     <= 1'b0;
      synced     <= 1'b0;
      ws_prev    <= 1'b0;
      cnt        <= '0;
      wpos       <= '0;
      acc        <= '0;
      rjsr       <= '0;
      close_stb  <= 1'b0;
      close_left <= 1'b0;
      close_ok   <= 1'b0;
      close_pack <= 1'b0;
      close_data <= '0;
    end else begin
      close_stb <= 1'b0;
      if (tick) begin
        primed  <= 1'b1;
        ws_prev <= ws;
        rjsr    <= {rjsr[RJ_W-2:0], sd};
        if (level_change) begin
          synced     <= 1'b1;
          close_stb  <= synced;
          close_left <= half_is_left(fmt_i2s, ws_prev);
          close_ok   <= len_ok;
          close_pack <= (cnt == PACK_LEN);
          close_data <= (fmt_i2s == FMT_I2S) ? acc_w : {rjsr, {PAD_W{1'b0}}};
          cnt        <= CNT_W'(1);
          wpos       <= '0;
          acc        <= '0;
        end else begin
          cnt  <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
          wpos <= (wpos == CNT_MAX) ? wpos : wpos + 1'b1;
          acc  <= acc_w;
        end
      end
    end
  end

  // R8
  close_pulse_chk: assert property (@(posedge clk) disable iff (rst) close_stb |=> !close_stb);
endmodule

// File: rtl/sar_pair.sv
module sar_pair #(
  parameter int SAMPLE_W = 24,
  parameter int PACK_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                close_stb,
  input  logic                close_left,
  input  logic                close_ok,
  input  logic                close_pack,
  input  logic [SAMPLE_W-1:0] close_data,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                pack_o,
  output logic                err_o
);
  localparam int PAD_W = SAMPLE_W - PACK_W;

  logic [SAMPLE_W-1:0] lbuf;
  logic                lok, lpack;

  always_ff @(posedge clk) begin
    if (rst) begin
      lbuf    <= '0;
      lok     <= 1'b0;
      lpack   <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
      pack_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (close_stb) begin
        if (!close_ok) err_o <= 1'b1;
        if (close_left) begin
          lok   <= close_ok;
          lbuf  <= close_data;
          lpack <= close_pack;
        end else begin
          lok <= 1'b0;
          if (close_ok && lok) begin
            left_o  <= lbuf;
            right_o <= close_data;
            pack_o  <= lpack & close_pack;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) valid_o |=> !valid_o);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_o |=> err_o);
  // R6
  pack_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && pack_o) |-> (left_o[PAD_W-1:0] == '0 && right_o[PAD_W-1:0] == '0));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx import sar_pkg::*; #(
  parameter int SAMPLE_W    = 24,
  parameter int RJ_W        = 16,
  parameter int PACK_W      = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fmt_i2s,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                pair_valid_o,
  output logic                pack16_o,
  output logic                frame_err_o
);
  localparam int PAD_W = SAMPLE_W - RJ_W;

  logic                tick, ws_s, sd_s;
  logic                c_stb, c_left, c_ok, c_pack;
  logic [SAMPLE_W-1:0] c_data;

  sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_i(bclk_i), .ws_i(lrclk_i), .sd_i(sdata_i),
    .tick_o(tick), .ws_o(ws_s), .sd_o(sd_s)
  );

  sar_deser #(.SAMPLE_W(SAMPLE_W), .RJ_W(RJ_W), .PACK_W(PACK_W), .CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst(rst), .fmt_i2s(fmt_i2s), .tick(tick), .ws(ws_s), .sd(sd_s),
    .close_stb(c_stb), .close_left(c_left), .close_ok(c_ok), .close_pack(c_pack),
    .close_data(c_data)
  );

  sar_pair #(.SAMPLE_W(SAMPLE_W), .PACK_W(PACK_W)) u_pair (
    .clk(clk), .rst(rst), .close_stb(c_stb), .close_left(c_left), .close_ok(c_ok),
    .close_pack(c_pack), .close_data(c_data),
    .left_o(left_o), .right_o(right_o), .valid_o(pair_valid_o),
    .pack_o(pack16_o), .err_o(frame_err_o)
  );

  // R4
  rj_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_valid_o && fmt_i2s == FMT_RJ) |->
      (left_o[PAD_W-1:0] == '0 && right_o[PAD_W-1:0] == '0));
endmodule

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fmt = 1'b1;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        pair_valid_o, pack16_o, frame_err_o;

  always #5 clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rst(rst), .fmt_i2s(fmt), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o),
    .pack16_o(pack16_o), .frame_err_o(frame_err_o)
  );

  int total = 0, bad = 0, pairs_seen = 0;
  bit done = 0;

  // reference model state
  logic [23:0] ql[$], qr[$];
  logic        qp[$];
  bit          have_prev, synced, m_lok, m_l16, exp_err, carry, prev_ws;
  int          prev_len;
  logic [23:0] prev_val, m_l;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every clock: any pulse must match the next expected pair
  bit prev_v = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pair_valid_o && prev_v) chk(0, "R8 pulse longer than one cycle", 1, 0);
      if (pair_valid_o) begin
        pairs_seen++;
        if (ql.size() == 0) chk(0, "R8 unexpected pair", {left_o, right_o}, 0);
        else begin
          logic [23:0] el, er; logic ep;
          el = ql.pop_front(); er = qr.pop_front(); ep = qp.pop_front();
          chk(left_o == el, "R2 R4 left sample", left_o, el);
          chk(right_o == er, "R2 R4 right sample", right_o, er);
          chk(pack16_o == ep, "R6 packed flag", pack16_o, ep);
        end
      end
    end
    prev_v = pair_valid_o;
  end

  function automatic bit pbit(input logic [31:0] word, input int w, input int p);
    return (p < w) ? word[w-1-p] : 1'b0;
  endfunction

  task automatic drive_tick(input bit ws, input bit b);
    @(negedge clk);
    bclk = 1'b0; lrclk = ws; sdata = b;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic model_close(input bit ws_new);
    if (have_prev && ws_new != prev_ws) begin
      if (synced) begin
        bit is_left, ok;
        is_left = fmt ? !prev_ws : prev_ws;
        ok = fmt ? (prev_len >= 24 || prev_len == 16) : (prev_len >= 16);
        if (!ok) exp_err = 1;
        if (is_left) begin
          m_lok = ok; m_l = prev_val; m_l16 = (prev_len == 16);
        end else begin
          if (ok && m_lok) begin
            ql.push_back(m_l); qr.push_back(prev_val); qp.push_back(m_l16 && prev_len == 16);
          end
          m_lok = 0;
        end
      end
      synced = 1;
    end
  endtask

  task automatic send_half(input bit ws, input int len, input int w, input logic [31:0] word);
    logic [23:0] val;
    model_close(ws);
    for (int k = 0; k < len; k++) begin
      bit b;
      if (fmt) b = (k == 0) ? carry : pbit(word, w, k - 1);
      else     b = (k >= len - 16) ? word[15 - (k - (len - 16))] : ~k[0];
      drive_tick(ws, b);
    end
    val = '0;
    if (fmt) begin
      carry = pbit(word, w, len - 1);
      for (int p = 0; p < len && p < 24; p++) val[23-p] = pbit(word, w, p);
    end else begin
      val = {word[15:0], 8'h00};
    end
    prev_ws = ws; prev_len = len; prev_val = val; have_prev = 1;
    repeat (4) @(negedge clk);
    chk(frame_err_o == exp_err, "R7 error flag", frame_err_o, exp_err);
    chk(ql.size() == 0, "R8 pair released after right half", ql.size(), 0);
  endtask

  task automatic do_reset(input bit f);
    @(negedge clk);
    rst = 1; fmt = f; bclk = 0; lrclk = 0; sdata = 0;
    repeat (4) @(negedge clk);
    chk(!pair_valid_o && !frame_err_o && !pack16_o && left_o == 0 && right_o == 0,
        "R10 outputs in reset", {pair_valid_o, frame_err_o, pack16_o, left_o, right_o}, 0);
    rst = 0;
    have_prev = 0; synced = 0; m_lok = 0; m_l16 = 0; exp_err = 0; carry = 0;
    ql.delete(); qr.delete(); qp.delete();
    @(negedge clk);
    chk(!pair_valid_o && !frame_err_o && left_o == 0 && right_o == 0,
        "R10 outputs after reset", {pair_valid_o, frame_err_o, left_o, right_o}, 0);
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      finish_up();
    end
  end

  initial begin
    // ---------------- I2S framing ----------------
    do_reset(1'b1);
    send_half(0, 40, 24, 32'hFFFFFF);              // R9 partial half at release of reset
    send_half(1, 32, 24, 32'h123456);              // right with no evaluated left
    chk(pairs_seen == 0, "R9 partial half produced a pair", pairs_seen, 0);
    send_half(0, 32, 24, 32'hA5A5A5);              // R1 R2
    send_half(1, 32, 24, 32'h5A5A5B);
    send_half(0, 32, 16, 32'hBEEF);                // R3 short words padded
    send_half(1, 32, 20, 32'hC3A71);
    send_half(0, 24, 24, 32'h800001);              // LSB carried on change edge
    send_half(1, 40, 32, 32'h13579BDF);            // R3 R11 long half, tail dropped
    send_half(0, 16, 16, 32'h8001);                // R6 packed
    send_half(1, 16, 16, 32'h7FFF);
    send_half(0, 16, 16, 32'h4321);                // R6 R11 mixed lengths
    send_half(1, 24, 24, 32'hFEDCBA);
    send_half(0, 20, 20, 32'hAAAAA);               // R7 short left
    send_half(1, 32, 24, 32'h111111);
    send_half(0, 32, 24, 32'h222222);              // recovery
    send_half(1, 32, 24, 32'h333333);
    send_half(0, 32, 24, 32'h444444);              // R7 short right on pair close
    send_half(1, 18, 18, 32'h3FFFF);
    send_half(0, 32, 24, 32'h654321);
    send_half(1, 28, 24, 32'h0F0F0F);
    send_half(0, 24, 24, 32'h000000);              // closes last right
    chk(frame_err_o == 1, "R7 sticky after errors", frame_err_o, 1);

    // ---------------- right-justified framing ----------------
    do_reset(1'b0);
    send_half(1, 20, 16, 32'hFFFF);                // R9
    send_half(0, 16, 16, 32'h5555);
    chk(pairs_seen == 14 - 7, "R9 partial half in RJ", pairs_seen, 7);
    send_half(1, 16, 16, 32'h1234);                // R4 R6
    send_half(0, 16, 16, 32'hABCD);
    send_half(1, 32, 16, 32'hF00F);                // R5 earlier bits ignored, R11
    send_half(0, 20, 16, 32'h0FF0);
    send_half(1, 12, 16, 32'h0123);                // R7 short half
    send_half(0, 16, 16, 32'h9876);
    send_half(1, 24, 16, 32'h8000);
    send_half(0, 24, 16, 32'h0001);
    send_half(1, 16, 16, 32'h0000);                // closes last right
    chk(frame_err_o == 1, "R7 sticky in RJ", frame_err_o, 1);

    done = 1;
    finish_up();
  end
endmodule